// File: doc/BRIEF.md
# Keyed Boot-ROM Call Gate

This block decides whether a call into a protected boot-ROM service routine may proceed inside a small 8-bit controller core. Software first stores a confirmation byte into a dedicated key location in data memory. That store arms a short window counted in retired instructions. The call instruction that follows is accepted only while the window is still open. An accepted call uses up the key, so each key permits one entry. Any other call raises a fault pulse, and the core must not enter the ROM.

While the core runs inside the boot ROM, the gate blocks interrupt delivery. The core's global enable input is only observed and is never changed. Each interrupt source has one pending flag. However many requests a source raises during ROM execution, they merge into a single pending event. That event is delivered once the routine returns to user code, provided the global enable is set. Instructions retired by an interrupt service routine between the key store and the call still count against the window, so an interrupt taken there can make the key lapse.

The controller is a three-state machine:
- **GATE_IDLE**: no key is live.
- **GATE_ARMED**: a key is live and its window is running.
- **GATE_IN_ROM**: validated boot-ROM execution.

Its transitions are:
- **arm**: IDLE→ARMED on a correct key store.
- **rearm**: ARMED→ARMED on a correct key store; the window is reloaded.
- **disarm**: ARMED→IDLE on a wrong byte stored to the key location.
- **lapse**: ARMED→IDLE when the last instruction of the window retires.
- **enter**: ARMED→IN_ROM on a call.
- **leave**: IN_ROM→IDLE on return.
- **reject**: a call in IDLE; the state is unchanged and a fault pulse is raised.

Top module: `bootcall_gate`

## Requirements
- R1: After reset, `call_valid`, `call_fault` and `in_rom` are low, `irq_out` is zero, and no key is live, so a call made then produces a fault.
- R2: A store with `key_wr_en` high, `key_wr_addr` equal to 0xE2 and `key_wr_data` equal to 0x98 arms the gate and loads a window of 6 instructions.
- R3: A store of 0x98 to any address other than 0xE2 does not arm the gate, so a following call faults.
- R4: A call is accepted when at most 5 `instr_retire` pulses fall strictly between the key-store cycle and the call cycle, which makes the call at most the 6th instruction after the key. With 6 or more such pulses the key has expired and the call faults. Retirements made by interrupt handlers count toward this total.
- R5: An accepted call makes `call_valid` high for exactly one cycle, in the cycle after `call_decode`. `in_rom` rises in that same cycle.
- R6: An accepted call consumes the key. A second call after leaving the ROM, with no new key store, faults.
- R7: A rejected call makes `call_fault` high for exactly one cycle, in the cycle after `call_decode`, and `in_rom` stays low.
- R8: Storing any byte other than 0x98 to 0xE2 disarms a live key at once, so a following call faults.
- R9: A correct key store while a key is live reloads the full 6-instruction window.
- R10: `in_rom` stays high until `rom_return` is sampled high, and drops in the next cycle. While `in_rom` is high, `call_decode` and key stores have no effect, so neither output pulses and no key is armed.
- R11: `irq_out` is all zero whenever `in_rom` is high or `gie` is low.
- R12: Each source keeps one pending flag. Any number of `irq_req` pulses from one source during ROM execution yield exactly one single-cycle `irq_out` pulse for that source once `in_rom` is low with `gie` high.
- R13: A request raised while `gie` is low stays pending and is delivered as a single pulse once `gie` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_retire | input | 1 | One pulse per retired instruction |
| key_wr_en | input | 1 | Data-memory store strobe |
| key_wr_addr | input | 8 | Store address |
| key_wr_data | input | 8 | Store data |
| call_decode | input | 1 | Boot-ROM call instruction executes |
| rom_return | input | 1 | Return from boot ROM to user code |
| gie | input | 1 | Global interrupt enable (observed only) |
| irq_req | input | NUM_IRQ | Interrupt request pulses, one bit per source |
| call_valid | output | 1 | One-cycle pulse: call accepted |
| call_fault | output | 1 | One-cycle pulse: call rejected |
| in_rom | output | 1 | Validated boot-ROM execution in progress |
| irq_out | output | NUM_IRQ | Gated interrupt delivery pulses |

## Verification
The bench builds the block with its defaults: key address 0xE2, key byte 0x98, a window of 6 and four interrupt sources. At that window size, the call can be placed directly on each side of the expiry boundary, at the 6th and the 7th instruction after the key. The boundary is also reached through a rearm midway through a window. Four sources are enough to show that coalescing is done per source. Requests repeated on one line during ROM execution merge into one pulse, while a request on another line is delivered separately.

// File: rtl/bootcall_pkg.sv
package bootcall_pkg;
    typedef enum logic [1:0] {
        GATE_IDLE   = 2'd0,
        GATE_ARMED  = 2'd1,
        GATE_IN_ROM = 2'd2
    } gate_state_t;
endpackage

// File: rtl/key_window.sv
// Instruction-counted lifetime of a stored key.
module key_window #(
    parameter int WINDOW = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] FULL = CW'(WINDOW);
    localparam logic [CW-1:0] ONE  = CW'(1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= FULL;
        end else if (clear) begin
            remain <= '0;
        end else if (tick && remain != '0) begin
            remain <= remain - ONE;
        end
    end

    assign last = (remain == ONE);
endmodule

// File: rtl/gate_fsm.sv
// Arm / enter / leave controller for the boot-ROM call.
module gate_fsm
    import bootcall_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_hit,
    input  logic key_match,
    input  logic call_decode,
    input  logic rom_return,
    input  logic instr_retire,
    input  logic win_last,
    output logic win_load,
    output logic win_clear,
    output logic call_valid,
    output logic call_fault,
    output logic in_rom
);
    gate_state_t state, state_nxt;
    logic        valid_nxt, fault_nxt;

    always_comb begin
        state_nxt = state;
        valid_nxt = 1'b0;
        fault_nxt = 1'b0;
        win_load  = 1'b0;
        win_clear = 1'b0;
        unique case (state)
            GATE_IDLE: begin
                fault_nxt = call_decode;                 // reject
                if (key_hit && key_match) begin          // arm
                    state_nxt = GATE_ARMED;
                    win_load  = 1'b1;
                end else if (key_hit) begin
                    win_clear = 1'b1;
                end
            end
            GATE_ARMED: begin
                if (call_decode) begin                   // enter
                    state_nxt = GATE_IN_ROM;
                    valid_nxt = 1'b1;
                    win_clear = 1'b1;
                end else if (key_hit && key_match) begin // rearm
                    win_load  = 1'b1;
                end else if (key_hit) begin              // disarm
                    state_nxt = GATE_IDLE;
                    win_clear = 1'b1;
                end else if (instr_retire && win_last) begin // lapse
                    state_nxt = GATE_IDLE;
                end
            end
            GATE_IN_ROM: begin
                if (rom_return) begin                    // leave
                    state_nxt = GATE_IDLE;
                end
            end
            default: state_nxt = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GATE_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            call_valid <= 1'b0;
            call_fault <= 1'b0;
        end else begin
            call_valid <= valid_nxt;
            call_fault <= fault_nxt;
        end
    end

    assign in_rom = (state == GATE_IN_ROM);
endmodule

// File: rtl/irq_gate.sv
// One pending flag per source; delivery blocked in ROM or with enable low.
module irq_gate #(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               gie,
    input  logic               in_rom,
    output logic [NUM_IRQ-1:0] irq_out
);
    logic               allow;
    logic [NUM_IRQ-1:0] pending;

    assign allow = gie && !in_rom;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pending[i] <= 1'b0;
            end else begin
                pending[i] <= irq_req[i] | (pending[i] & ~allow);
            end
        end
        assign irq_out[i] = pending[i] & allow;
    end
endmodule

// File: rtl/bootcall_gate.sv
module bootcall_gate #(
    parameter int         NUM_IRQ  = 4,
    parameter int         WINDOW   = 6,
    parameter logic [7:0] KEY_ADDR = 8'hE2,
    parameter logic [7:0] KEY_CODE = 8'h98
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_retire,
    input  logic               key_wr_en,
    input  logic [7:0]         key_wr_addr,
    input  logic [7:0]         key_wr_data,
    input  logic               call_decode,
    input  logic               rom_return,
    input  logic               gie,
    input  logic [NUM_IRQ-1:0] irq_req,
    output logic               call_valid,
    output logic               call_fault,
    output logic               in_rom,
    output logic [NUM_IRQ-1:0] irq_out
);
    logic key_hit, key_match, win_load, win_clear, win_last;

    assign key_hit   = key_wr_en && (key_wr_addr == KEY_ADDR);
    assign key_match = (key_wr_data == KEY_CODE);

    key_window #(.WINDOW(WINDOW)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (win_load),
        .clear (win_clear),
        .tick  (instr_retire),
        .last  (win_last)
    );

    gate_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .key_hit      (key_hit),
        .key_match    (key_match),
        .call_decode  (call_decode),
        .rom_return   (rom_return),
        .instr_retire (instr_retire),
        .win_last     (win_last),
        .win_load     (win_load),
        .win_clear    (win_clear),
        .call_valid   (call_valid),
        .call_fault   (call_fault),
        .in_rom       (in_rom)
    );

    irq_gate #(.NUM_IRQ(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .gie     (gie),
        .in_rom  (in_rom),
        .irq_out (irq_out)
    );
endmodule

// File: rtl/bootcall_gate_chk.sv
module bootcall_gate_chk #(
    parameter int NUM_IRQ = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               call_decode,
    input logic               rom_return,
    input logic               gie,
    input logic               call_valid,
    input logic               call_fault,
    input logic               in_rom,
    input logic [NUM_IRQ-1:0] irq_out
);
    AST_VALID_AFTER_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        call_valid |-> $past(call_decode)); // R5
    AST_VALID_IN_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        call_valid |-> in_rom); // R5
    AST_FAULT_AFTER_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        call_fault |-> $past(call_decode)); // R7
    AST_FAULT_NO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        call_fault |-> !in_rom); // R7
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(call_valid && call_fault)); // R7
    AST_ROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rom && !rom_return) |=> in_rom); // R10
    AST_ROM_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rom && rom_return) |=> !in_rom); // R10
    AST_IRQ_MASK_ROM: assert property (@(posedge clk) disable iff (!rst_n)
        in_rom |-> (irq_out == '0)); // R11
    AST_IRQ_MASK_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (irq_out == '0)); // R11
endmodule

bind bootcall_gate bootcall_gate_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .call_decode (call_decode),
    .rom_return  (rom_return),
    .gie         (gie),
    .call_valid  (call_valid),
    .call_fault  (call_fault),
    .in_rom      (in_rom),
    .irq_out     (irq_out)
);

// File: tb/bootcall_gate_bench.sv
module bootcall_gate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_retire = 1'b0;
    logic          key_wr_en = 1'b0;
    logic [7:0]    key_wr_addr = 8'h00;
    logic [7:0]    key_wr_data = 8'h00;
    logic          call_decode = 1'b0;
    logic          rom_return = 1'b0;
    logic          gie = 1'b1;
    logic [NI-1:0] irq_req = '0;
    logic          call_valid, call_fault, in_rom;
    logic [NI-1:0] irq_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bootcall_gate u_bootcall_gate (
        .clk(clk), .rst_n(rst_n), .instr_retire(instr_retire),
        .key_wr_en(key_wr_en), .key_wr_addr(key_wr_addr), .key_wr_data(key_wr_data),
        .call_decode(call_decode), .rom_return(rom_return), .gie(gie),
        .irq_req(irq_req), .call_valid(call_valid), .call_fault(call_fault),
        .in_rom(in_rom), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    // one clock: inputs already driven at negedge, pulses cleared afterwards
    task automatic step();
        @(negedge clk);
        cycles++;
        instr_retire = 1'b0;
        key_wr_en    = 1'b0;
        call_decode  = 1'b0;
        rom_return   = 1'b0;
        irq_req      = '0;
    endtask

    task automatic store(input logic [7:0] a, input logic [7:0] d);
        key_wr_en = 1'b1; key_wr_addr = a; key_wr_data = d; instr_retire = 1'b1;
        step();
    endtask

    task automatic retire(input int n);
        for (int i = 0; i < n; i++) begin
            instr_retire = 1'b1;
            step();
        end
    endtask

    // issue a call; check pulse of the following cycle
    task automatic call(input string tag, input logic exp_ok);
        call_decode = 1'b1; instr_retire = 1'b1;
        step();
        check({tag, " call_valid"}, call_valid, exp_ok);
        check({tag, " call_fault"}, call_fault, !exp_ok);
        check({tag, " in_rom"}, in_rom, exp_ok);
    endtask

    task automatic leave();
        rom_return = 1'b1; instr_retire = 1'b1;
        step();
        check("R10 in_rom drops after return", in_rom, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 call_valid", call_valid, 1'b0);
        check("R1 call_fault", call_fault, 1'b0);
        check("R1 in_rom", in_rom, 1'b0);
        check("R1 irq_out", irq_out, '0);
        call("R1 no key after reset", 1'b0);
        step();
        check("R7 fault is one cycle", call_fault, 1'b0);
    endtask

    task automatic t_window();
        store(8'hE2, 8'h98);
        retire(5);
        call("R2 R4 sixth instruction accepted", 1'b1);
        step();
        check("R5 valid is one cycle", call_valid, 1'b0);
        check("R5 still in rom", in_rom, 1'b1);
        leave();
        store(8'hE2, 8'h98);
        retire(6);
        call("R4 seventh instruction expired", 1'b0);
        // interrupt handler retirements also use up the window
        store(8'hE2, 8'h98);
        retire(2);
        retire(4);
        call("R4 handler retirements expire key", 1'b0);
    endtask

    task automatic t_addr();
        store(8'hE3, 8'h98);
        call("R3 other address does not arm", 1'b0);
    endtask

    task automatic t_consume();
        store(8'hE2, 8'h98);
        call("R6 first call", 1'b1);
        leave();
        call("R6 key consumed", 1'b0);
    endtask

    task automatic t_wrong();
        store(8'hE2, 8'h98);
        retire(1);
        store(8'hE2, 8'h97);
        call("R8 wrong byte disarms", 1'b0);
    endtask

    task automatic t_rearm();
        store(8'hE2, 8'h98);
        retire(4);
        store(8'hE2, 8'h98);
        retire(5);
        call("R9 rearm reloads window", 1'b1);
        leave();
    endtask

    task automatic t_rom_ignore();
        store(8'hE2, 8'h98);
        call("R10 enter", 1'b1);
        call_decode = 1'b1;
        step();
        check("R10 call in rom no valid", call_valid, 1'b0);
        check("R10 call in rom no fault", call_fault, 1'b0);
        check("R10 stays in rom", in_rom, 1'b1);
        store(8'hE2, 8'h98);
        check("R10 key store in rom", in_rom, 1'b1);
        leave();
        call("R10 key stored in rom not armed", 1'b0);
    endtask

    task automatic t_irq();
        int c0, c1, c2, c3;
        gie = 1'b1;
        store(8'hE2, 8'h98);
        call("R11 enter", 1'b1);
        for (int i = 0; i < 3; i++) begin
            irq_req = 4'b0001;
            step();
            check("R11 masked in rom", irq_out, 4'b0000);
            step();
        end
        irq_req = 4'b0100;
        step();
        check("R11 masked in rom src2", irq_out, 4'b0000);
        rom_return = 1'b1;
        step();
        c0 = 0; c1 = 0; c2 = 0; c3 = 0;
        for (int k = 0; k < 5; k++) begin
            #1;
            c0 += int'(irq_out[0]); c1 += int'(irq_out[1]);
            c2 += int'(irq_out[2]); c3 += int'(irq_out[3]);
            step();
        end
        check("R12 src0 coalesced to one", c0, 1);
        check("R12 src2 one pulse", c2, 1);
        check("R12 src1 none", c1, 0);
        check("R12 src3 none", c3, 0);
        gie = 1'b0;
        irq_req = 4'b0010;
        step();
        retire(3);
        check("R11 masked with gie low", irq_out, 4'b0000);
        gie = 1'b1;
        #1;
        check("R13 delivered on gie", irq_out, 4'b0010);
        step();
        check("R13 single pulse", irq_out, 4'b0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window();
        t_addr();
        t_consume();
        t_wrong();
        t_rearm();
        t_rom_ignore();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule